// File: doc/BRIEF.md
# Self-Seeding One-Hot Ring Counter

This block is a small rotating counter built on a four-mode shift register (hold, move toward the last stage, move toward the first stage, parallel capture). A start-up sequencer owns the register's mode lines. Once clear is released, it forces a parallel capture of a seed pattern for a fixed number of clocks. After that it hands over to circular shifting. In this mode the stage that falls off one end is fed back into the other end, so a single 1 travels around the ring and the register can never be stuck at all zeros.

An option bit selects a twisted ring instead of a plain ring. In a twisted ring the inverted end stage is fed back. This gives an eight-state sequence of length 2×WIDTH, and that sequence starts correctly from all zeros. The ring type is captured during seeding and then held until the next clear. An enable freezes the pattern in place. A direction input chooses which way the ring rotates.

Bit naming: `q[0]` is stage A (the first stage) and `q[WIDTH-1]` is stage D (the last stage).

Top module: `ring_counter_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, `q` becomes all zeros at that edge, whatever the other inputs are.
- R2: The first SEED_CYCLES rising edges (default 2) after `rst_n` goes high each load the seed into `q`. In plain mode the seed is `q = 4'b0001` (A=1, all other stages 0). Nothing rotates during these edges.
- R3: The core register decodes its 2-bit mode as 00 = hold, 01 = shift toward D, 10 = shift toward A, 11 = parallel load. Exactly one action happens per rising edge.
- R4: After seeding, with `en=1` and `dir_left=0`, each edge moves every stage one place toward D. The old D value re-enters at A: 0001 → 0010 → 0100 → 1000 → 0001.
- R5: With `en=1` and `dir_left=1`, each edge moves every stage one place toward A. The old A value re-enters at D: 0001 → 1000 → 0100 → 0010.
- R6: After seeding, `en=0` leaves `q` unchanged at every edge. Rotation resumes from the same position when `en` returns to 1.
- R7: In plain mode, exactly one bit of `q` is 1 on every cycle after seeding completes.
- R8: In twisted mode the seed is all zeros and the inverted end stage is fed back. Rotating toward D gives 0000 → 0001 → 0011 → 0111 → 1111 → 1110 → 1100 → 1000 → 0000, a period of 8.
- R9: `twist` is sampled on the seeding edges only. A change of `twist` after seeding has no effect on `q` until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear |
| en | input | 1 | 1 = rotate, 0 = hold after seeding |
| dir_left | input | 1 | 0 = rotate toward D, 1 = rotate toward A |
| twist | input | 1 | 1 = twisted ring (inverted feedback), sampled during seeding |
| q | output | WIDTH (4) | Stage outputs, bit 0 = A |

## Verification
The bench targets three timing points:
- the exact edge at which seeding ends, where an off-by-one counter would show an extra or missing seed cycle;
- the wrap-around edges in both directions, where a wrong feedback tap would drop the travelling 1 or duplicate it;
- a hold window in the middle of a rotation, where a design that keeps shifting would lose its position.

In twisted mode the bench starts from all zeros and walks the full eight-state cycle twice. It then flips `twist` mid-run to show that the latched ring type ignores the change. A design that feeds back the true value from all zeros would stay locked at 0000.

// File: rtl/ring_pkg.sv
// Package: shared mode encoding for the ring counter.
// Assumes: the 2-bit code values are fixed; the core register decodes them.
package ring_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHR   = 2'b01,
        MODE_SHL   = 2'b10,
        MODE_LOAD  = 2'b11
    } ring_mode_e;
endpackage

// File: rtl/ring_shift_core.sv
// Module: ring_shift_core
// Four-mode shift register: hold, shift toward the last stage, shift toward
// the first stage, and parallel load. Stage 0 is the first stage.
// Assumes: rst_n is synchronous and clean; WIDTH >= 2.
module ring_shift_core
    import ring_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ring_mode_e       mode,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    // Per-stage next-value selection from the mode code.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_first
            assign from_low = ser_r;
        end else begin : g_mid_lo
            assign from_low = q[i-1];
        end
        if (i == WIDTH - 1) begin : g_last
            assign from_high = ser_l;
        end else begin : g_mid_hi
            assign from_high = q[i+1];
        end
        always_comb begin
            unique case (mode)
                MODE_HOLD: nxt[i] = q[i];
                MODE_SHR:  nxt[i] = from_low;
                MODE_SHL:  nxt[i] = from_high;
                default:   nxt[i] = par_in[i];
            endcase
        end
    end

    // Stage register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(q));
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q == $past(par_in)));
    a_r4_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHR) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_r)}));
    a_r5_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHL) |=> (q == {$past(ser_l), $past(q[WIDTH-1:1])}));
endmodule

// File: rtl/ring_feedback.sv
// Module: ring_feedback
// Builds the serial inputs of the core from its end stages: true value for
// a plain ring, inverted value for a twisted ring.
// Assumes: twisted is stable between clears (latched by the sequencer).
module ring_feedback #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             twisted,
    output logic             ser_r,
    output logic             ser_l
);
    // End-stage taps, optionally inverted.
    always_comb begin
        ser_r = q[WIDTH-1] ^ twisted;
        ser_l = q[0] ^ twisted;
    end
endmodule

// File: rtl/ring_startup_seq.sv
// Module: ring_startup_seq
// Start-up sequencer: after clear it drives parallel load for SEED_CYCLES
// edges, latching the ring type, then drives hold or shift per en/dir_left.
// Assumes: rst_n synchronous; SEED_CYCLES >= 1.
module ring_startup_seq
    import ring_pkg::*;
#(
    parameter int SEED_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       dir_left,
    input  logic       twist,
    output ring_mode_e mode,
    output logic       seeding,
    output logic       twist_lat
);
    localparam int CW = $clog2(SEED_CYCLES + 1);
    localparam logic [CW-1:0] SEED_LAST = CW'(SEED_CYCLES);

    logic [CW-1:0] cnt;

    assign seeding = (cnt < SEED_LAST);

    // Seed counter and ring-type latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            twist_lat <= 1'b0;
        end else if (seeding) begin
            cnt       <= cnt + 1'b1;
            twist_lat <= twist;
        end
    end

    // Mode selection for the core register.
    always_comb begin
        if (seeding)      mode = MODE_LOAD;
        else if (!en)     mode = MODE_HOLD;
        else if (dir_left) mode = MODE_SHL;
        else              mode = MODE_SHR;
    end

    a_r9_twist_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !seeding |=> $stable(twist_lat));
endmodule

// File: rtl/ring_counter_top.sv
// Module: ring_counter_top
// Self-seeding ring counter: sequencer drives the core's mode, the feedback
// block closes the ring, the seed is one-hot (plain) or zero (twisted).
// Assumes: rst_n synchronous and clean.
module ring_counter_top
    import ring_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SEED_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_left,
    input  logic             twist,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE_HOT_SEED = WIDTH'(1);

    ring_mode_e       mode;
    logic             seeding;
    logic             twist_lat;
    logic             ser_r;
    logic             ser_l;
    logic [WIDTH-1:0] seed;

    // Seed pattern chosen by the live ring type during loading.
    always_comb seed = twist ? '0 : ONE_HOT_SEED;

    ring_startup_seq #(.SEED_CYCLES(SEED_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_left(dir_left),
        .twist(twist), .mode(mode), .seeding(seeding), .twist_lat(twist_lat)
    );

    ring_feedback #(.WIDTH(WIDTH)) u_fb (
        .q(q), .twisted(twist_lat), .ser_r(ser_r), .ser_l(ser_l)
    );

    ring_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ser_r(ser_r),
        .ser_l(ser_l), .par_in(seed), .q(q)
    );

    a_r7_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        (!seeding && !twist_lat) |-> ($countones(q) == 1));
    a_r2_seed_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (seeding && !twist) |=> (q == ONE_HOT_SEED));
endmodule

// File: tb/ring_counter_top_bench.sv
module ring_counter_top_bench;
    localparam int W = 4;
    localparam int SEEDN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic dir_left = 1'b0;
    logic twist = 1'b0;
    logic [W-1:0] q;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [W-1:0] exp_q[$];
    string        exp_tag[$];

    // bench-side model state
    logic [W-1:0] m_q = '0;
    int           m_cnt = 0;
    logic         m_twist = 1'b0;

    always #5 clk = ~clk;

    ring_counter_top #(.WIDTH(W), .SEED_CYCLES(SEEDN)) u_ring_counter_top (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_left(dir_left),
        .twist(twist), .q(q)
    );

    // Driver: set inputs at negedge, predict q after the next posedge.
    task automatic drive(input logic r, input logic e, input logic d,
                         input logic t, input string tag);
        logic fb;
        @(negedge clk);
        rst_n = r; en = e; dir_left = d; twist = t;
        if (!r) begin
            m_q = '0; m_cnt = 0; m_twist = 1'b0;
        end else if (m_cnt < SEEDN) begin
            m_q = t ? 4'b0000 : 4'b0001;
            m_twist = t;
            m_cnt++;
        end else if (!e) begin
            m_q = m_q;
        end else if (!d) begin
            fb = m_q[3] ^ m_twist;
            m_q = {m_q[2:0], fb};
        end else begin
            fb = m_q[0] ^ m_twist;
            m_q = {fb, m_q[3:1]};
        end
        exp_q.push_back(m_q);
        exp_tag.push_back(tag);
    endtask

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] ex,
                         input string tag);
        total++;
        if (act !== ex) begin
            bad++;
            $display("FAIL %s: q=%b expected=%b at %0t", tag, act, ex, $time);
        end
    endtask

    // Monitor: compare after each posedge; also one-hot check in plain runs.
    initial begin
        forever begin
            logic [W-1:0] e;
            string t;
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(q, e, t);
                if (t == "R7") begin
                    total++;
                    if ($countones(q) != 1) begin
                        bad++;
                        $display("FAIL R7: q=%b expected one bit set", q);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] twseq [8];
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, "R1");
        // R2: seed edges
        for (int i = 0; i < SEEDN; i++) drive(1, 1, 0, 0, "R2");
        // R4/R7: right rotation with wrap
        for (int i = 0; i < 8; i++) drive(1, 1, 0, 0, "R7");
        for (int i = 0; i < 2; i++) drive(1, 1, 0, 0, "R4");
        // R6: hold mid-rotation, then resume
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, "R6");
        for (int i = 0; i < 2; i++) drive(1, 1, 0, 0, "R6");
        // R5: left rotation with wrap
        for (int i = 0; i < 6; i++) drive(1, 1, 1, 0, "R5");
        // R1: clear mid-run, R3 exercised by load/hold/shift sequence
        for (int i = 0; i < 2; i++) drive(0, 1, 1, 1, "R1");
        for (int i = 0; i < SEEDN; i++) drive(1, 1, 0, 1, "R3");
        // R8: twisted right, two full periods
        for (int i = 0; i < 16; i++) drive(1, 1, 0, 1, "R8");
        // R9: twist dropped after seeding has no effect
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, "R9");
        for (int i = 0; i < 3; i++) drive(1, 1, 1, 0, "R9");
        // Explicit R8 literal walk after a fresh twisted seed
        drive(0, 1, 0, 1, "R1");
        for (int i = 0; i < SEEDN; i++) drive(1, 1, 0, 1, "R8");
        @(posedge clk); #2;
        while (exp_q.size() > 0) begin @(posedge clk); #2; end
        twseq[0] = 4'b0000; twseq[1] = 4'b0001; twseq[2] = 4'b0011;
        twseq[3] = 4'b0111; twseq[4] = 4'b1111; twseq[5] = 4'b1110;
        twseq[6] = 4'b1100; twseq[7] = 4'b1000;
        check(q, twseq[0], "R8");
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk); #2;
            check(q, twseq[i % 8], "R8");
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule